// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the state of a bank of interrupt sources and turns their activity into delivery requests for a downstream presentation unit. Each source is fixed at build time as either level-triggered or edge-triggered (message style). Each one carries a programmable destination server, a priority and a saved priority. A priority of all ones masks the source. Level sources track their input and remember whether a request is already outstanding. Edge sources remember edges that arrived while masked, and deliveries that the presentation unit turned back.

The presentation unit answers with reject and end-of-interrupt commands, which carry a global source number. It can also ask for a resend. A resend starts a scan over the bank in ascending index order. The scan offers each source that qualifies, one at a time, and waits until the previous request has been taken. Requests leave through a single valid/ready port that carries the global number (local index plus a base offset), the server and the priority.

Two state machines drive the block. The offer machine has the states OFFER_EMPTY and OFFER_FULL. It moves OFFER_EMPTY to OFFER_FULL when it loads a queued, unmasked source, and OFFER_FULL to OFFER_EMPTY when the request is accepted. The scan machine has the states SCAN_IDLE and SCAN_WALK. It moves SCAN_IDLE to SCAN_WALK on a resend request. It returns SCAN_WALK to SCAN_IDLE after it has visited the last index, and it advances only while nothing is queued or offered.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset no request is offered, and every source reads back priority 0xFF and saved priority 0xFF through the query port. The source type is fixed by the LSI_MASK parameter: bit i set means source i is level-triggered; clear means edge-triggered.
- R2: A rising edge on an edge-triggered source with priority other than 0xFF produces one request. The request carries number index+BASE and the source's server and priority. An edge that arrives while the priority is 0xFF produces no request and is remembered as pending.
- R3: A configuration write updates the server, priority and saved priority, which the query port shows on the next cycle. If an edge source has a pending masked edge and the new priority is not 0xFF, it is delivered once and the pending mark is cleared.
- R4: A level source produces a request when its input rises, on a configuration write, or during a resend. It does so only if its priority is not 0xFF, its input is high and no earlier request is outstanding. Issuing the request marks it outstanding, and a steady high level does not repeat it.
- R5: A reject of an edge source marks it rejected. A reject of a level source clears its outstanding mark. Neither one produces a request by itself.
- R6: A resend visits sources in ascending index order. An edge source marked rejected loses the mark and is delivered if unmasked. A level source that meets the R4 conditions is delivered. A second resend with no new reject delivers nothing.
- R7: An end-of-interrupt clears the outstanding mark of a level source, so the next resend delivers it again. On an edge source it has no effect, so its rejected mark survives.
- R8: Reject and end-of-interrupt numbers outside BASE to BASE+NSRC-1 change no source.
- R9: At most one request is offered at a time. Its number, server and priority stay stable until it is accepted. Requests queued in the same cycle leave in ascending index order, whatever their priorities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Per-source input: level for level sources, pulse for edge sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index of the source being configured |
| cfg_server | input | SRV_W | New destination server |
| cfg_prio | input | PRIO_W | New priority (all ones = masked) |
| cfg_saved | input | PRIO_W | New saved priority |
| qry_idx | input | IDX_W | Local index to read back |
| qry_prio | output | PRIO_W | Priority of the queried source |
| qry_saved | output | PRIO_W | Saved priority of the queried source |
| rej_valid | input | 1 | Reject command strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend_req | input | 1 | Starts a resend scan |
| dlv_valid | output | 1 | A delivery request is offered |
| dlv_ready | input | 1 | Presentation unit accepts the request |
| dlv_num | output | NUM_W | Global source number of the request |
| dlv_server | output | SRV_W | Destination server of the request |
| dlv_prio | output | PRIO_W | Priority of the request |

## Verification
The bench builds the block with eight sources, BASE of 16 and LSI_MASK 0x0F. This gives four level sources (numbers 16 to 19) and four edge sources (numbers 20 to 23). With both types present, one resend scan can mix level and edge redelivery, and a reject or end-of-interrupt can be aimed at either type. The 8-bit number width leaves room for numbers below the base and above the top of the bank. Those numbers wrap or alias onto a real source if the range check is missing.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

    typedef enum logic {
        OFFER_EMPTY = 1'b0,
        OFFER_FULL  = 1'b1
    } offer_state_e;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_WALK = 1'b1
    } scan_state_e;

endpackage

// File: rtl/irq_src_slice.sv
module irq_src_slice #(
    parameter bit IS_LSI = 1'b0,
    parameter int SRV_W  = 4,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic              cfg_hit,
    input  logic [SRV_W-1:0]  cfg_server,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic [PRIO_W-1:0] cfg_saved,
    input  logic              clr_hit,
    input  logic              scan_hit,
    input  logic              take,
    output logic              queued,
    output logic [PRIO_W-1:0] prio,
    output logic [PRIO_W-1:0] saved,
    output logic [SRV_W-1:0]  server
);
    localparam logic [PRIO_W-1:0] MASKED = {PRIO_W{1'b1}};

    logic              lvl_q;
    logic [PRIO_W-1:0] p_eff;
    logic              p_ok;
    logic              take_drop;
    logic              q_set;

    // priority that applies this cycle, a write in flight included
    assign p_eff     = cfg_hit ? cfg_prio : prio;
    assign p_ok      = (p_eff != MASKED);
    // a queued source that got masked before it was offered is sent back
    assign take_drop = take && (prio == MASKED);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            queued <= 1'b0;
            prio   <= MASKED;
            saved  <= MASKED;
            server <= '0;
        end else begin
            lvl_q  <= lvl;
            queued <= (queued & ~take) | q_set;
            if (cfg_hit) begin
                prio   <= cfg_prio;
                saved  <= cfg_saved;
                server <= cfg_server;
            end
        end
    end

    generate
        if (IS_LSI) begin : g_level
            logic sent_q;
            logic sent_base;
            logic fire;

            always_comb begin
                sent_base = sent_q & ~clr_hit & ~take_drop;
                fire      = ((lvl & ~lvl_q) | cfg_hit | scan_hit) & p_ok & lvl & ~sent_base;
                q_set     = fire;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) sent_q <= 1'b0;
                else        sent_q <= sent_base | fire;
            end
        end else begin : g_edge
            logic rej_q;
            logic mpend_q;
            logic edge_seen;
            logic release_ok;
            logic redo;

            always_comb begin
                edge_seen  = lvl & ~lvl_q;
                release_ok = cfg_hit & mpend_q & p_ok;
                redo       = scan_hit & rej_q;
                q_set      = (edge_seen & p_ok) | release_ok | (redo & p_ok);
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rej_q   <= 1'b0;
                    mpend_q <= 1'b0;
                end else begin
                    rej_q   <= (rej_q & ~scan_hit) | clr_hit;
                    mpend_q <= (mpend_q & ~release_ok) | (edge_seen & ~p_ok) | take_drop;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irq_src_pick.sv
module irq_src_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_src_scan.sv
module irq_src_scan
    import irq_src_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int IDX_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            busy,
    output logic [NSRC-1:0] hit
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NSRC - 1);

    scan_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCAN_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            SCAN_IDLE: begin
                if (start) begin
                    state_d = SCAN_WALK;
                    idx_d   = '0;
                end
            end
            SCAN_WALK: begin
                if (!busy) begin
                    if (idx_q == LAST) state_d = SCAN_IDLE;
                    else               idx_d   = idx_q + 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        hit = '0;
        if (state_q == SCAN_WALK && !busy) begin
            for (int i = 0; i < NSRC; i++) hit[i] = (idx_q == IDX_W'(i));
        end
    end
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
    import irq_src_pkg::*;
#(
    parameter int              NSRC     = 8,
    parameter int              SRV_W    = 4,
    parameter int              PRIO_W   = 8,
    parameter int              NUM_W    = 8,
    parameter int              BASE     = 16,
    parameter logic [NSRC-1:0] LSI_MASK = 8'h0F,
    localparam int             IDX_W    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [SRV_W-1:0]  cfg_server,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic [PRIO_W-1:0] cfg_saved,
    input  logic [IDX_W-1:0]  qry_idx,
    output logic [PRIO_W-1:0] qry_prio,
    output logic [PRIO_W-1:0] qry_saved,
    input  logic              rej_valid,
    input  logic [NUM_W-1:0]  rej_num,
    input  logic              eoi_valid,
    input  logic [NUM_W-1:0]  eoi_num,
    input  logic              resend_req,
    output logic              dlv_valid,
    input  logic              dlv_ready,
    output logic [NUM_W-1:0]  dlv_num,
    output logic [SRV_W-1:0]  dlv_server,
    output logic [PRIO_W-1:0] dlv_prio
);
    localparam logic [PRIO_W-1:0] MASKED = {PRIO_W{1'b1}};
    localparam logic [NUM_W-1:0]  BASE_N = NUM_W'(BASE);
    localparam logic [NUM_W-1:0]  SPAN_N = NUM_W'(NSRC);

    logic [NSRC-1:0]   queued_v, take_v, scan_v, cfg_v, rej_v, eoi_v, clr_v;
    logic [PRIO_W-1:0] prio_a   [NSRC];
    logic [PRIO_W-1:0] saved_a  [NSRC];
    logic [SRV_W-1:0]  server_a [NSRC];

    logic [NUM_W-1:0]  rej_off, eoi_off;
    logic              rej_in, eoi_in;
    logic              any_q, busy, load_go, load_ok;
    logic [IDX_W-1:0]  pick_idx;

    offer_state_e      off_q, off_d;
    logic [IDX_W-1:0]  off_idx;
    logic [SRV_W-1:0]  off_srv;
    logic [PRIO_W-1:0] off_prio;

    // global number decode for the commands coming back
    always_comb begin
        rej_off = rej_num - BASE_N;
        eoi_off = eoi_num - BASE_N;
        rej_in  = rej_valid && (rej_num >= BASE_N) && (rej_off < SPAN_N);
        eoi_in  = eoi_valid && (eoi_num >= BASE_N) && (eoi_off < SPAN_N);
        for (int i = 0; i < NSRC; i++) begin
            cfg_v[i] = cfg_we && (cfg_idx == IDX_W'(i));
            rej_v[i] = rej_in && (rej_off == NUM_W'(i));
            eoi_v[i] = eoi_in && (eoi_off == NUM_W'(i));
            // completion only matters to level sources
            clr_v[i] = rej_v[i] | (eoi_v[i] & LSI_MASK[i]);
        end
    end

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            irq_src_slice #(
                .IS_LSI (LSI_MASK[g]),
                .SRV_W  (SRV_W),
                .PRIO_W (PRIO_W)
            ) u_slice (
                .clk        (clk),
                .rst_n      (rst_n),
                .lvl        (src_in[g]),
                .cfg_hit    (cfg_v[g]),
                .cfg_server (cfg_server),
                .cfg_prio   (cfg_prio),
                .cfg_saved  (cfg_saved),
                .clr_hit    (clr_v[g]),
                .scan_hit   (scan_v[g]),
                .take       (take_v[g]),
                .queued     (queued_v[g]),
                .prio       (prio_a[g]),
                .saved      (saved_a[g]),
                .server     (server_a[g])
            );
        end
    endgenerate

    irq_src_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
        .req (queued_v),
        .any (any_q),
        .idx (pick_idx)
    );

    assign busy = (off_q == OFFER_FULL) || any_q;

    irq_src_scan #(.NSRC(NSRC), .IDX_W(IDX_W)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .start (resend_req),
        .busy  (busy),
        .hit   (scan_v)
    );

    always_comb begin
        load_go = (off_q == OFFER_EMPTY) && any_q;
        load_ok = (prio_a[pick_idx] != MASKED);
        for (int i = 0; i < NSRC; i++) take_v[i] = load_go && (pick_idx == IDX_W'(i));
    end

    // offer state register
    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= OFFER_EMPTY;
        else        off_q <= off_d;
    end

    always_comb begin
        off_d = off_q;
        unique case (off_q)
            OFFER_EMPTY: if (load_go && load_ok) off_d = OFFER_FULL;
            OFFER_FULL:  if (dlv_ready)          off_d = OFFER_EMPTY;
        endcase
    end

    // offer payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_idx  <= '0;
            off_srv  <= '0;
            off_prio <= MASKED;
        end else if (load_go && load_ok) begin
            off_idx  <= pick_idx;
            off_srv  <= server_a[pick_idx];
            off_prio <= prio_a[pick_idx];
        end
    end

    assign dlv_valid  = (off_q == OFFER_FULL);
    assign dlv_num    = NUM_W'(off_idx) + BASE_N;
    assign dlv_server = off_srv;
    assign dlv_prio   = off_prio;
    assign qry_prio   = prio_a[qry_idx];
    assign qry_saved  = saved_a[qry_idx];

endmodule

// File: rtl/irq_src_ctrl_chk.sv
module irq_src_ctrl_chk #(
    parameter int NSRC   = 8,
    parameter int SRV_W  = 4,
    parameter int PRIO_W = 8,
    parameter int NUM_W  = 8,
    parameter int BASE   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dlv_valid,
    input logic              dlv_ready,
    input logic [NUM_W-1:0]  dlv_num,
    input logic [SRV_W-1:0]  dlv_server,
    input logic [PRIO_W-1:0] dlv_prio
);
    a_r9_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_num)
                                    && $stable(dlv_server) && $stable(dlv_prio));

    a_r9_single_offer: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && dlv_ready |=> !dlv_valid);

    a_r2_no_masked_offer: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> dlv_prio != {PRIO_W{1'b1}});

    a_r8_num_in_bank: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_num >= NUM_W'(BASE)) && (dlv_num < NUM_W'(BASE + NSRC)));

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dlv_valid);
endmodule

bind irq_src_ctrl irq_src_ctrl_chk #(
    .NSRC(NSRC), .SRV_W(SRV_W), .PRIO_W(PRIO_W), .NUM_W(NUM_W), .BASE(BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dlv_valid  (dlv_valid),
    .dlv_ready  (dlv_ready),
    .dlv_num    (dlv_num),
    .dlv_server (dlv_server),
    .dlv_prio   (dlv_prio)
);

// File: tb/irq_src_ctrl_test.sv
module irq_src_ctrl_test;
    localparam int NSRC = 8;
    localparam int BASE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_in = '0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic [3:0] cfg_server = '0;
    logic [7:0] cfg_prio = '0, cfg_saved = '0;
    logic [2:0] qry_idx = '0;
    logic [7:0] qry_prio, qry_saved;
    logic       rej_valid = 1'b0, eoi_valid = 1'b0, resend_req = 1'b0;
    logic [7:0] rej_num = '0, eoi_num = '0;
    logic       dlv_valid, dlv_ready = 1'b0;
    logic [7:0] dlv_num, dlv_prio;
    logic [3:0] dlv_server;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_src_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
        .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
        .qry_idx(qry_idx), .qry_prio(qry_prio), .qry_saved(qry_saved),
        .rej_valid(rej_valid), .rej_num(rej_num),
        .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend_req(resend_req),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_num(dlv_num),
        .dlv_server(dlv_server), .dlv_prio(dlv_prio)
    );

    function automatic int gnum(input int idx);
        return idx + BASE;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input int srv, input int prio, input int saved);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_server = 4'(srv);
        cfg_prio = 8'(prio); cfg_saved = 8'(saved);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk); src_in[idx] = 1'b1;
        @(negedge clk); src_in[idx] = 1'b0;
    endtask

    task automatic set_lvl(input int idx, input bit v);
        @(negedge clk); src_in[idx] = v;
    endtask

    task automatic rej(input int num);
        @(negedge clk); rej_valid = 1'b1; rej_num = 8'(num);
        @(negedge clk); rej_valid = 1'b0;
    endtask

    task automatic eoi(input int num);
        @(negedge clk); eoi_valid = 1'b1; eoi_num = 8'(num);
        @(negedge clk); eoi_valid = 1'b0;
    endtask

    task automatic resend();
        @(negedge clk); resend_req = 1'b1;
        @(negedge clk); resend_req = 1'b0;
    endtask

    task automatic take(input int num, input int srv, input int prio, input string tag);
        int n = 0;
        int d = int'($urandom % 3);
        while (!dlv_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(dlv_valid == 1'b1, {tag, " offer present"}, int'(dlv_valid), 1);
        chk(int'(dlv_num) == num, {tag, " number"}, int'(dlv_num), num);
        chk(int'(dlv_server) == srv, {tag, " server"}, int'(dlv_server), srv);
        chk(int'(dlv_prio) == prio, {tag, " priority"}, int'(dlv_prio), prio);
        for (int k = 0; k < d; k++) begin
            @(negedge clk);
            chk(dlv_valid && int'(dlv_num) == num, "R9 offer held", int'(dlv_num), num);
        end
        dlv_ready = 1'b1;
        @(negedge clk);
        dlv_ready = 1'b0;
    endtask

    task automatic none(input int cycles, input string tag);
        bit seen = 1'b0;
        int num = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (dlv_valid && !seen) begin seen = 1'b1; num = int'(dlv_num); end
        end
        chk(!seen, {tag, " no request"}, num, 0);
        if (seen) begin
            dlv_ready = 1'b1; @(negedge clk); dlv_ready = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(!dlv_valid, "R1 idle after reset", int'(dlv_valid), 0);
        for (int i = 0; i < NSRC; i++) begin
            qry_idx = 3'(i); #1;
            chk(qry_prio == 8'hFF && qry_saved == 8'hFF, "R1 reset priorities",
                int'(qry_prio), 255);
        end

        // R2/R3: masked edge held, released by configuration
        pulse(4);
        none(6, "R2 masked edge");
        cfg(4, 3, 5, 5);
        take(gnum(4), 3, 5, "R3 pending release");
        cfg(4, 3, 6, 6);
        none(6, "R3 pending cleared");

        // R2, R5, R7, R6 on an edge source
        cfg(5, 1, 2, 2);
        pulse(5);
        take(gnum(5), 1, 2, "R2 edge delivery");
        rej(gnum(5));
        none(5, "R5 edge reject");
        eoi(gnum(5));
        resend();
        take(gnum(5), 1, 2, "R7 edge eoi ignored, R6 resend");
        resend();
        none(14, "R6 rejected flag cleared");

        // R4, R7, R5 on a level source
        cfg(0, 2, 4, 4);
        set_lvl(0, 1'b1);
        take(gnum(0), 2, 4, "R4 level rise");
        none(6, "R4 steady level");
        eoi(gnum(0));
        none(4, "R7 eoi alone");
        resend();
        take(gnum(0), 2, 4, "R7 level after eoi");
        rej(gnum(0));
        none(4, "R5 level reject");
        resend();
        take(gnum(0), 2, 4, "R6 level resend");
        set_lvl(0, 1'b0);
        eoi(gnum(0));
        resend();
        none(14, "R6 level low");

        // R4/R3: masked level released by configuration
        set_lvl(1, 1'b1);
        none(5, "R4 masked level");
        cfg(1, 5, 3, 3);
        take(gnum(1), 5, 3, "R3 level config");
        set_lvl(1, 1'b0);

        // R8: out-of-range numbers
        rej(BASE + NSRC + 5);
        rej(5);
        eoi(BASE + NSRC);
        resend();
        none(14, "R8 out of range");

        // R3: query of written values
        cfg(7, 7, 1, 9);
        cfg(6, 6, 7, 7);
        @(negedge clk); qry_idx = 3'd7; #1;
        chk(qry_prio == 8'd1, "R3 query priority", int'(qry_prio), 1);
        chk(qry_saved == 8'd9, "R3 query saved", int'(qry_saved), 9);

        // R9: simultaneous edges leave in index order
        @(negedge clk); src_in[4] = 1'b1; src_in[6] = 1'b1; src_in[7] = 1'b1;
        @(negedge clk); src_in[4] = 1'b0; src_in[6] = 1'b0; src_in[7] = 1'b0;
        take(gnum(4), 3, 6, "R9 order first");
        take(gnum(6), 6, 7, "R9 order second");
        take(gnum(7), 7, 1, "R9 order third");

        // R6: mixed scan in ascending order
        set_lvl(0, 1'b1);
        take(gnum(0), 2, 4, "R4 level again");
        eoi(gnum(0));
        rej(gnum(7));
        rej(gnum(5));
        resend();
        take(gnum(0), 2, 4, "R6 scan slot 0");
        take(gnum(5), 1, 2, "R6 scan slot 5");
        take(gnum(7), 7, 1, "R6 scan slot 7");
        set_lvl(0, 1'b0);

        // R2/R9: random edge traffic
        for (int k = 0; k < 30; k++) begin
            int idx = 4 + int'($urandom % 4);
            int pr  = int'($urandom % 255);
            int sv  = int'($urandom % 16);
            cfg(idx, sv, pr, pr);
            pulse(idx);
            take(gnum(idx), sv, pr, "R2 random edge");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule